// File: doc/BRIEF.md
# Scheduled Operand Collector for a Dual-Pipe Lane

This block is the register-access stage of one lane that feeds a multiply-add pipe followed by an add pipe. Each cycle it accepts one decoded instruction. It gathers up to five operands: three for the multiply-add pipe and two for the add pipe. In the same cycle it retires the previous instruction's two results into a register file with four ports. Two ports only read, one only writes, and one is switched per instruction between reading and writing. Hardware never detects hazards. The instruction states which port reads or writes which register, and where every operand comes from.

An operand can come from one of three read ports. It can also be the low or high half of a 64-bit constant carried in the clause, or one of two forwarding temporaries that hold the prior instruction's results. An add-pipe operand can instead be marked to take the multiply-add result of the same instruction. The register file is split per warp: a warp has either 32 or 64 registers, and choosing 64 halves the number of warps that can be addressed.

The operands, their forwarding flags and three error flags appear one cycle after the instruction is presented.

Top module: `operand_collector`

## Requirements
- R1: While reset is active and on the first cycle after it, `op_valid`, `enc_err`, `tmp_err`, `rng_err` and both forward flags are low.
- R2: Each operand has a 3-bit source code. The operand fields are packed in this order: multiply-add a, b, c, then add a, b. Codes 0, 1 and 2 return the data of read port 0, read port 1 and the shared port, and each port reads the register named by its own index field. Results appear on the cycle after the instruction, and a cycle with no instruction gives `op_valid` low.
- R3: A register that is read and written back by the same instruction returns its value from before that write.
- R4: When `wr_src` is 0, the write port stores the multiply-add result and a shared-port write stores the add result. When `wr_src` is 1, the two are swapped.
- R5: When the write port and a shared-port write name the same register, the write port's value is the one kept.
- R6: Code 3 returns bits [31:0] of the clause constant, and code 4 returns bits [63:32].
- R7: Code 5 returns the multiply-add result, and code 6 the add result, that arrive with the instruction. These are the prior instruction's results.
- R8: Code 5 or 6 raises `tmp_err` when used in the first instruction of a clause or when the previous cycle carried no instruction.
- R9: Code 7 on an add operand sets that operand's forward flag and drives its data to zero. Code 7 on a multiply-add operand raises `enc_err`.
- R10: `enc_err` is also raised when the shared port is set to read and write at once, or when an operand selects a read port whose enable is low.
- R11: An instruction that raises any error gives `op_valid` low and writes no register.
- R12: The register address is {warp, index[4:0]} when `wide_mode` is 0, and {warp[W-2:0], index[5:0]} when it is 1. So with 64 registers, warp 1 register 3 is the same storage as warp 2 register 3 with 32 registers.
- R13: An enabled port raises `rng_err` if its index is 32 or more when `wide_mode` is 0, or if the warp's top bit is set when `wide_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| clause_start | input | 1 | Instruction is the first of its clause |
| warp_id | input | log2(NUM_WARPS) | Warp owning the instruction |
| wide_mode | input | 1 | 1: 64 registers per warp, 0: 32 |
| instr_bits | input | INS_W | Packed port-assignment and source-select fields |
| konst | input | 2*DW | Clause-embedded constant |
| fma_res | input | DW | Multiply-add result of the prior instruction |
| add_res | input | DW | Add result of the prior instruction |
| op_valid | output | 1 | Operands below are valid |
| fma_a | output | DW | Multiply-add operand a |
| fma_b | output | DW | Multiply-add operand b |
| fma_c | output | DW | Multiply-add operand c |
| add_a | output | DW | Add operand a |
| add_b | output | DW | Add operand b |
| add_a_fwd | output | 1 | Add operand a takes the multiply-add result |
| add_b_fwd | output | 1 | Add operand b takes the multiply-add result |
| enc_err | output | 1 | Illegal encoding |
| tmp_err | output | 1 | Temporary read without a valid predecessor |
| rng_err | output | 1 | Register address out of range |

## Verification
The main function is driven by a sequence of instructions run back to back. Each step mixes a different set of sources over the five operands, so a wrong source code or a swapped port shows up as a distinct value. Some steps read a register in the cycle it is rewritten, which separates old data from new data. Others write one register through both write paths at once, which exposes which path wins. A register written under one width mode is read back under the other, which pins down the address layout. Each error case is placed just before a read of the register it tried to modify, so a write that should have been suppressed is caught at the outputs.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int IDX_W   = 6;
    localparam int SEL_W   = 3;
    localparam int NUM_OPS = 5;

    localparam int OP_FA = 0;
    localparam int OP_FB = 1;
    localparam int OP_FC = 2;
    localparam int OP_AA = 3;
    localparam int OP_AB = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_P0    = 3'd0,
        SRC_P1    = 3'd1,
        SRC_PS    = 3'd2,
        SRC_KLO   = 3'd3,
        SRC_KHI   = 3'd4,
        SRC_TM    = 3'd5,
        SRC_TA    = 3'd6,
        SRC_CHAIN = 3'd7
    } src_e;

    typedef struct packed {
        logic                             rd0_en;
        logic [IDX_W-1:0]                 rd0_idx;
        logic                             rd1_en;
        logic [IDX_W-1:0]                 rd1_idx;
        logic                             sh_rd;
        logic                             sh_wr;
        logic [IDX_W-1:0]                 sh_idx;
        logic                             wr_en;
        logic                             wr_src;
        logic [IDX_W-1:0]                 wr_idx;
        logic [NUM_OPS-1:0][SEL_W-1:0]    sel;
    } ins_t;

    localparam int INS_W = $bits(ins_t);

endpackage

// File: rtl/oc_addr.sv
module oc_addr
    import oc_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int WARP_W    = $clog2(NUM_WARPS),
    parameter int AW        = WARP_W + IDX_W - 1
) (
    input  logic [WARP_W-1:0] warp,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wide,
    output logic [AW-1:0]     addr,
    output logic              bad
);

    localparam int NARROW_W = IDX_W - 1;

    always_comb begin
        if (wide) begin
            addr = {warp[WARP_W-2:0], idx};
            bad  = warp[WARP_W-1];
        end else begin
            addr = {warp, idx[NARROW_W-1:0]};
            bad  = idx[IDX_W-1];
        end
    end

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
    parameter int DW  = 32,
    parameter int AW  = 8,
    parameter int NRD = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata,
    input  logic                     we_w,
    input  logic [AW-1:0]            waddr_w,
    input  logic [DW-1:0]            wdata_w,
    input  logic                     we_s,
    input  logic [AW-1:0]            waddr_s,
    input  logic [DW-1:0]            wdata_s
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Shared-port write first, write port second: the write port wins a collision.
    always_ff @(posedge clk) begin
        if (we_s) mem_q[waddr_s] <= wdata_s;
        if (we_w) mem_q[waddr_w] <= wdata_w;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem_q[raddr[r]];
    end

    // R5
    wr_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_w && we_s && (waddr_w == waddr_s))
        |=> (mem_q[$past(waddr_w)] == $past(wdata_w)));

endmodule

// File: rtl/oc_src_mux.sv
module oc_src_mux
    import oc_pkg::*;
#(
    parameter int DW     = 32,
    parameter bit IS_ADD = 1'b0
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [2:0]           rd_en,
    input  logic [2:0][DW-1:0]   rdata,
    input  logic [2*DW-1:0]      konst,
    input  logic [DW-1:0]        fma_res,
    input  logic [DW-1:0]        add_res,
    output logic [DW-1:0]        data,
    output logic                 fwd,
    output logic                 uses_tmp,
    output logic                 bad
);

    always_comb begin
        data     = '0;
        fwd      = 1'b0;
        uses_tmp = 1'b0;
        bad      = 1'b0;
        case (src_e'(sel))
            SRC_P0: begin
                data = rdata[0];
                bad  = !rd_en[0];
            end
            SRC_P1: begin
                data = rdata[1];
                bad  = !rd_en[1];
            end
            SRC_PS: begin
                data = rdata[2];
                bad  = !rd_en[2];
            end
            SRC_KLO: data = konst[DW-1:0];
            SRC_KHI: data = konst[2*DW-1:DW];
            SRC_TM: begin
                data     = fma_res;
                uses_tmp = 1'b1;
            end
            SRC_TA: begin
                data     = add_res;
                uses_tmp = 1'b1;
            end
            SRC_CHAIN: begin
                if (IS_ADD) fwd = 1'b1;
                else        bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/operand_collector.sv
module operand_collector
    import oc_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NUM_WARPS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         instr_valid,
    input  logic                         clause_start,
    input  logic [$clog2(NUM_WARPS)-1:0] warp_id,
    input  logic                         wide_mode,
    input  logic [INS_W-1:0]             instr_bits,
    input  logic [2*DW-1:0]              konst,
    input  logic [DW-1:0]                fma_res,
    input  logic [DW-1:0]                add_res,
    output logic                         op_valid,
    output logic [DW-1:0]                fma_a,
    output logic [DW-1:0]                fma_b,
    output logic [DW-1:0]                fma_c,
    output logic [DW-1:0]                add_a,
    output logic [DW-1:0]                add_b,
    output logic                         add_a_fwd,
    output logic                         add_b_fwd,
    output logic                         enc_err,
    output logic                         tmp_err,
    output logic                         rng_err
);

    localparam int WARP_W = $clog2(NUM_WARPS);
    localparam int AW     = WARP_W + IDX_W - 1;
    localparam int NPORT  = 4;
    localparam int NRD    = 3;
    localparam int P_SH   = 2;
    localparam int P_WR   = 3;

    typedef struct packed {
        logic                          valid;
        logic [NUM_OPS-1:0][DW-1:0]    data;
        logic [1:0]                    fwd;
        logic                          enc;
        logic                          tmp;
        logic                          rng;
        logic                          prev;
    } st_t;

    ins_t ins;
    assign ins = ins_t'(instr_bits);

    // Address formation for rd0, rd1, shared, write.
    logic [NPORT-1:0][IDX_W-1:0] p_idx;
    logic [NPORT-1:0]            p_en;
    logic [NPORT-1:0][AW-1:0]    p_addr;
    logic [NPORT-1:0]            p_bad;

    assign p_idx = {ins.wr_idx, ins.sh_idx, ins.rd1_idx, ins.rd0_idx};
    assign p_en  = {ins.wr_en, ins.sh_rd | ins.sh_wr, ins.rd1_en, ins.rd0_en};

    for (genvar p = 0; p < NPORT; p++) begin : g_addr
        oc_addr #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .AW(AW)) u_addr (
            .warp (warp_id),
            .idx  (p_idx[p]),
            .wide (wide_mode),
            .addr (p_addr[p]),
            .bad  (p_bad[p])
        );
    end

    // Register file
    logic [NRD-1:0][AW-1:0] rf_raddr;
    logic [NRD-1:0][DW-1:0] rf_rdata;
    logic [NRD-1:0]         rf_ren;
    logic                   rf_we_w, rf_we_s;
    logic [DW-1:0]          rf_wdata_w, rf_wdata_s;

    assign rf_raddr = {p_addr[P_SH], p_addr[1], p_addr[0]};
    assign rf_ren   = {ins.sh_rd, ins.rd1_en, ins.rd0_en};

    assign rf_wdata_w = ins.wr_src ? add_res : fma_res;
    assign rf_wdata_s = ins.wr_src ? fma_res : add_res;

    oc_regfile #(.DW(DW), .AW(AW), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr   (rf_raddr),
        .rdata   (rf_rdata),
        .we_w    (rf_we_w),
        .waddr_w (p_addr[P_WR]),
        .wdata_w (rf_wdata_w),
        .we_s    (rf_we_s),
        .waddr_s (p_addr[P_SH]),
        .wdata_s (rf_wdata_s)
    );

    // Operand source selection
    logic [NUM_OPS-1:0][DW-1:0] op_data;
    logic [NUM_OPS-1:0]         op_fwd;
    logic [NUM_OPS-1:0]         op_tmp;
    logic [NUM_OPS-1:0]         op_bad;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        oc_src_mux #(.DW(DW), .IS_ADD(o >= OP_AA)) u_mux (
            .sel      (ins.sel[o]),
            .rd_en    (rf_ren),
            .rdata    (rf_rdata),
            .konst    (konst),
            .fma_res  (fma_res),
            .add_res  (add_res),
            .data     (op_data[o]),
            .fwd      (op_fwd[o]),
            .uses_tmp (op_tmp[o]),
            .bad      (op_bad[o])
        );
    end

    // Next-state logic
    st_t  st_d, st_q;
    logic enc_any, tmp_any, rng_any, err_any;

    always_comb begin
        enc_any = (ins.sh_rd & ins.sh_wr) | (|op_bad);
        tmp_any = (|op_tmp) & (clause_start | !st_q.prev);
        rng_any = |(p_en & p_bad);
        err_any = enc_any | tmp_any | rng_any;

        rf_we_w = instr_valid & ins.wr_en & !err_any;
        rf_we_s = instr_valid & ins.sh_wr & !err_any;

        st_d       = st_q;
        st_d.prev  = instr_valid;
        st_d.valid = instr_valid & !err_any;
        st_d.enc   = instr_valid & enc_any;
        st_d.tmp   = instr_valid & tmp_any;
        st_d.rng   = instr_valid & rng_any;
        st_d.data  = op_data;
        st_d.fwd   = {op_fwd[OP_AB], op_fwd[OP_AA]} & {2{instr_valid & !err_any}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op_valid  = st_q.valid;
    assign fma_a     = st_q.data[OP_FA];
    assign fma_b     = st_q.data[OP_FB];
    assign fma_c     = st_q.data[OP_FC];
    assign add_a     = st_q.data[OP_AA];
    assign add_b     = st_q.data[OP_AB];
    assign add_a_fwd = st_q.fwd[0];
    assign add_b_fwd = st_q.fwd[1];
    assign enc_err   = st_q.enc;
    assign tmp_err   = st_q.tmp;
    assign rng_err   = st_q.rng;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(instr_valid));

    // R8
    tmp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && clause_start && (|op_tmp)) |=> (tmp_err && !op_valid));

    // R11
    no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_w || rf_we_s) |=> (!enc_err && !tmp_err && !rng_err));

    // R9
    chain_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (src_e'(ins.sel[OP_AA]) == SRC_CHAIN)) |=> (!op_valid || add_a_fwd));

    // R13
    rng_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !wide_mode && ins.rd0_en && ins.rd0_idx[IDX_W-1]) |=> (rng_err && !op_valid));

endmodule

// File: tb/operand_collector_tb.sv
module operand_collector_tb;
    import oc_pkg::*;

    localparam int DW = 32;
    localparam int NW = 8;

    localparam logic [2:0] P0 = 3'd0, P1 = 3'd1, PS = 3'd2, KL = 3'd3, KH = 3'd4,
                           TM = 3'd5, TA = 3'd6, CH = 3'd7;

    localparam logic [31:0] A1 = 32'h1111_0001, A2 = 32'h2222_0002;
    localparam logic [31:0] B1 = 32'h3333_0003, B2 = 32'h4444_0004;
    localparam logic [31:0] C1 = 32'h5555_0005, C2 = 32'h6666_0006;
    localparam logic [31:0] D1 = 32'h7777_0007, E1 = 32'h8888_0008;
    localparam logic [31:0] F1 = 32'h9999_0009;
    localparam logic [63:0] K0 = {32'hC0DE_0001, 32'h0000_00AA};
    localparam logic [63:0] K1 = {32'hBEEF_0002, 32'h0000_00BB};
    localparam logic [31:0] L0 = 32'h0000_00AA;

    function automatic ins_t mk(
        input logic e0, input logic [5:0] i0,
        input logic e1, input logic [5:0] i1,
        input logic sr, input logic sw, input logic [5:0] si,
        input logic we, input logic ws, input logic [5:0] wi,
        input logic [2:0] s0, input logic [2:0] s1, input logic [2:0] s2,
        input logic [2:0] s3, input logic [2:0] s4);
        ins_t r;
        r.rd0_en = e0; r.rd0_idx = i0;
        r.rd1_en = e1; r.rd1_idx = i1;
        r.sh_rd  = sr; r.sh_wr = sw; r.sh_idx = si;
        r.wr_en  = we; r.wr_src = ws; r.wr_idx = wi;
        r.sel    = {s4, s3, s2, s1, s0};
        return r;
    endfunction

    typedef struct packed {
        logic                  cs;
        logic [2:0]            warp;
        logic                  wide;
        ins_t                  ins;
        logic [31:0]           fr;
        logic [31:0]           ar;
        logic [63:0]           k;
        logic                  ev;
        logic [2:0]            ee;   // {enc, tmp, rng}
        logic [4:0][31:0]      ed;   // {ab, aa, fc, fb, fa}
        logic [1:0]            ef;   // {add_b_fwd, add_a_fwd}
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd1, 1'b0, mk(0,0, 0,0, 0,1,4, 1,0,3, KL,KL,KL,KL,KL), A1, A2, K0,
          1'b1, 3'b000, {L0,L0,L0,L0,L0}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(1,3, 1,4, 1,0,3, 1,1,3, P0,P1,PS,TM,TA), B1, B2, K0,
          1'b1, 3'b000, {B2,B1,A1,A2,A1}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(1,3, 0,0, 0,1,6, 1,0,6, P0,KH,KL,CH,P0), C1, C2, K1,
          1'b1, 3'b000, {B2,32'h0,32'h0000_00BB,32'hBEEF_0002,B2}, 2'b01},
        '{1'b1, 3'd1, 1'b0, mk(0,0, 0,0, 0,0,0, 1,0,3, KL,KL,KL,TM,KL), D1, D1, K0,
          1'b0, 3'b010, {5{32'h0}}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(1,3, 1,6, 0,0,0, 0,0,0, P0,P1,KL,KL,KL), D1, D1, K0,
          1'b1, 3'b000, {L0,L0,L0,C1,B2}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(0,0, 0,0, 1,1,6, 1,0,6, KL,KL,KL,KL,KL), E1, E1, K0,
          1'b0, 3'b100, {5{32'h0}}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(0,0, 0,0, 0,0,0, 0,0,0, CH,KL,KL,KL,KL), E1, E1, K0,
          1'b0, 3'b100, {5{32'h0}}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(0,0, 0,0, 0,0,0, 0,0,0, KL,P1,KL,KL,KL), E1, E1, K0,
          1'b0, 3'b100, {5{32'h0}}, 2'b00},
        '{1'b1, 3'd1, 1'b0, mk(1,6, 0,0, 0,0,0, 0,0,0, P0,KL,KL,KL,KL), E1, E1, K0,
          1'b1, 3'b000, {L0,L0,L0,L0,C1}, 2'b00},
        '{1'b0, 3'd1, 1'b0, mk(1,40, 0,0, 0,0,0, 0,0,0, P0,KL,KL,KL,KL), E1, E1, K0,
          1'b0, 3'b001, {5{32'h0}}, 2'b00},
        '{1'b1, 3'd1, 1'b1, mk(0,0, 0,0, 0,0,0, 1,0,3, KL,KL,KL,KL,KL), F1, E1, K0,
          1'b1, 3'b000, {L0,L0,L0,L0,L0}, 2'b00},
        '{1'b1, 3'd2, 1'b0, mk(1,3, 0,0, 0,0,0, 0,0,0, P0,KL,KL,KL,KL), E1, E1, K0,
          1'b1, 3'b000, {L0,L0,L0,L0,F1}, 2'b00},
        '{1'b1, 3'd1, 1'b0, mk(1,3, 0,0, 0,0,0, 0,0,0, P0,KL,KL,KL,KL), E1, E1, K0,
          1'b1, 3'b000, {L0,L0,L0,L0,B2}, 2'b00},
        '{1'b1, 3'd4, 1'b1, mk(1,3, 0,0, 0,0,0, 0,0,0, P0,KL,KL,KL,KL), E1, E1, K0,
          1'b0, 3'b001, {5{32'h0}}, 2'b00}
    };

    function automatic string tag(input int i);
        case (i)
            0:  return "R4 R6";
            1:  return "R2 R3 R4 R7";
            2:  return "R5 R6 R9";
            3:  return "R8 R11";
            4:  return "R11 R5";
            5:  return "R10";
            6:  return "R9";
            7:  return "R10";
            8:  return "R11";
            9:  return "R13";
            10: return "R12";
            11: return "R12";
            12: return "R12";
            default: return "R13";
        endcase
    endfunction

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_valid = 1'b0;
    logic              clause_start = 1'b0;
    logic [2:0]        warp_id = '0;
    logic              wide_mode = 1'b0;
    logic [INS_W-1:0]  instr_bits = '0;
    logic [63:0]       konst = '0;
    logic [31:0]       fma_res = '0, add_res = '0;
    logic              op_valid, add_a_fwd, add_b_fwd, enc_err, tmp_err, rng_err;
    logic [31:0]       fma_a, fma_b, fma_c, add_a, add_b;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    operand_collector #(.DW(DW), .NUM_WARPS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .clause_start(clause_start),
        .warp_id(warp_id), .wide_mode(wide_mode), .instr_bits(instr_bits), .konst(konst),
        .fma_res(fma_res), .add_res(add_res), .op_valid(op_valid),
        .fma_a(fma_a), .fma_b(fma_b), .fma_c(fma_c), .add_a(add_a), .add_b(add_b),
        .add_a_fwd(add_a_fwd), .add_b_fwd(add_b_fwd),
        .enc_err(enc_err), .tmp_err(tmp_err), .rng_err(rng_err)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        instr_valid  = 1'b1;
        clause_start = v.cs;
        warp_id      = v.warp;
        wide_mode    = v.wide;
        instr_bits   = v.ins;
        konst        = v.k;
        fma_res      = v.fr;
        add_res      = v.ar;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "flags in reset", {58'h0, op_valid, enc_err, tmp_err, rng_err, add_a_fwd, add_b_fwd}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "flags after reset", {58'h0, op_valid, enc_err, tmp_err, rng_err, add_a_fwd, add_b_fwd}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            chk(tag(i), $sformatf("vec%0d valid/errors", i),
                {60'h0, op_valid, enc_err, tmp_err, rng_err}, {60'h0, VECS[i].ev, VECS[i].ee});
            if (VECS[i].ev) begin
                chk(tag(i), $sformatf("vec%0d fma_a", i), {32'h0, fma_a}, {32'h0, VECS[i].ed[0]});
                chk(tag(i), $sformatf("vec%0d fma_b", i), {32'h0, fma_b}, {32'h0, VECS[i].ed[1]});
                chk(tag(i), $sformatf("vec%0d fma_c", i), {32'h0, fma_c}, {32'h0, VECS[i].ed[2]});
                chk(tag(i), $sformatf("vec%0d add_a", i), {32'h0, add_a}, {32'h0, VECS[i].ed[3]});
                chk(tag(i), $sformatf("vec%0d add_b", i), {32'h0, add_b}, {32'h0, VECS[i].ed[4]});
                chk(tag(i), $sformatf("vec%0d fwd", i), {62'h0, add_b_fwd, add_a_fwd}, {62'h0, VECS[i].ef});
            end
        end

        // R2: an idle cycle produces no valid operands
        instr_valid = 1'b0;
        @(negedge clk);
        chk("R2", "idle op_valid", {63'h0, op_valid}, 64'h0);

        // R8: temporary read after an idle cycle, mid-clause
        drive('{1'b0, 3'd1, 1'b0, mk(0,0, 0,0, 0,0,0, 0,0,0, KL,KL,KL,KL,TA), A1, A2, K0,
                1'b0, 3'b000, {5{32'h0}}, 2'b00});
        @(negedge clk);
        chk("R8", "temp after idle", {62'h0, tmp_err, op_valid}, {62'h0, 1'b1, 1'b0});

        // R7: now a valid predecessor exists, same temp read succeeds
        drive('{1'b0, 3'd1, 1'b0, mk(0,0, 0,0, 0,0,0, 0,0,0, TM,KL,KL,KL,TA), C1, C2, K0,
                1'b0, 3'b000, {5{32'h0}}, 2'b00});
        @(negedge clk);
        chk("R7", "temp after valid", {62'h0, tmp_err, op_valid}, {62'h0, 1'b0, 1'b1});
        chk("R7", "temp mul-add data", {32'h0, fma_a}, {32'h0, C1});
        chk("R7", "temp add data", {32'h0, add_b}, {32'h0, C2});

        // R9: chaining on add operand b
        drive('{1'b0, 3'd1, 1'b0, mk(0,0, 0,0, 0,0,0, 0,0,0, KL,KL,KL,KL,CH), C1, C2, K0,
                1'b0, 3'b000, {5{32'h0}}, 2'b00});
        @(negedge clk);
        chk("R9", "chain b flags", {61'h0, op_valid, add_b_fwd, add_a_fwd}, {61'h0, 1'b1, 1'b1, 1'b0});
        chk("R9", "chain b data", {32'h0, add_b}, 64'h0);

        instr_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule